// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block turns one runtime element count into a series of vector operations, none longer than the hardware maximum vector length (MVL). A requester presents a 16-bit element count and a base element index together with a start strobe. The sequencer then hands out strips one at a time over a valid/ready handshake. Each strip carries its start index, its length and a flag that marks the final strip.

The short piece comes first. The count modulo MVL is issued as the opening strip, and every strip after it is a full MVL strip. This means a consumer that sets its vector length once for the short piece can then keep the maximum length for the rest of the loop. A count that is an exact multiple of MVL yields only full strips. A zero count yields no strip and reports completion at once. A one-cycle `done` pulse closes every sequence.

Top module: `strip_seq`

## Requirements
- R1: When the count modulo MVL is nonzero, the first strip has length equal to count modulo MVL.
- R2: Every strip after the first has length exactly MVL (default 64).
- R3: The first strip starts at the base index. Each later strip starts at the previous start plus the previous length, modulo 2^16.
- R4: The number of strips emitted is floor(count/MVL), plus one when count modulo MVL is nonzero.
- R5: Every emitted strip length lies between 1 and MVL.
- R6: When the count is a nonzero multiple of MVL, no zero-length strip is emitted. The sequence is exactly count/MVL full strips.
- R7: When the count is 0, no strip is emitted and `done` is 1 in the cycle after the start edge.
- R8: While `stripValid` is 1 and `stripReady` is 0, the start, length and last outputs hold their values.
- R9: `stripLast` is 1 on the final strip of a sequence and 0 on every other strip.
- R10: `startValid` is ignored while `busy` is 1. The strips in progress are unaffected, and no extra strip follows.
- R11: After reset, `stripValid`, `done` and `busy` are 0.
- R12: The first strip is valid in the cycle after the start edge. `done` pulses for one cycle in the cycle after the edge that accepts the last strip, and `stripValid` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start request; taken when `busy` is 0 |
| count | input | 16 | Element count for the sequence |
| baseIdx | input | 16 | Element index of the first element |
| busy | output | 1 | A sequence is being emitted |
| stripValid | output | 1 | A strip is offered |
| stripReady | input | 1 | Consumer accepts the offered strip |
| stripStart | output | 16 | Start element index of the strip |
| stripLen | output | 7 | Strip length, 1 to MVL |
| stripLast | output | 1 | Marks the final strip |
| done | output | 1 | One-cycle completion pulse |

## Verification
A start request taken at a clock edge shows its first strip (or, for a zero count, its `done` pulse) one edge later. Each accepting edge exposes the next strip one edge later. `done` follows the accepting edge of the last strip by one edge. The bench drives inputs just after rising edges and samples on falling edges. At the falling edge after a start it checks for the first strip or the `done` pulse. At the falling edge after the last strip is accepted it checks `done`. A scoreboard queue built from the count alone is compared strip by strip against every accepted strip, under several ready patterns.

// File: rtl/strip_pkg.sv
package strip_pkg;

  typedef struct packed {
    logic load;     // capture count and base, set first length
    logic advance;  // current strip accepted, step to next
  } ctrlStrobe_t;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_EMIT = 1'b1
  } seqState_t;

endpackage

// File: rtl/strip_ctrl.sv
module strip_ctrl
  import strip_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        countZero,
  input  logic        stripReady,
  input  logic        isLast,
  output ctrlStrobe_t strobe,
  output logic        stripValid,
  output logic        busy,
  output logic        done
);

  seqState_t stateQ, stateD;
  logic      doneQ, doneD;

  always_comb begin
    stateD         = stateQ;
    doneD          = 1'b0;
    strobe.load    = 1'b0;
    strobe.advance = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (startValid) begin
          if (countZero) begin
            doneD = 1'b1;
          end else begin
            strobe.load = 1'b1;
            stateD      = S_EMIT;
          end
        end
      end
      S_EMIT: begin
        if (stripReady) begin
          strobe.advance = 1'b1;
          if (isLast) begin
            stateD = S_IDLE;
            doneD  = 1'b1;
          end
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= doneD;
    end
  end

  assign stripValid = (stateQ == S_EMIT);
  assign busy       = (stateQ == S_EMIT);
  assign done       = doneQ;

  // R12: a completion pulse never overlaps an offered strip
  p_done_alone_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !stripValid);

  // R12: done lasts a single cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: a zero count never opens a sequence
  p_zero_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid && countZero) |=> (!stripValid && done));

endmodule

// File: rtl/strip_dp.sv
module strip_dp
  import strip_pkg::*;
#(
  parameter int MVL   = 64,
  parameter int CNT_W = 16,
  parameter int IDX_W = 16,
  parameter int LEN_W = $clog2(MVL + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [CNT_W-1:0] count,
  input  logic [IDX_W-1:0] baseIdx,
  output logic [IDX_W-1:0] stripStart,
  output logic [LEN_W-1:0] stripLen,
  output logic             isLast
);

  localparam logic [CNT_W-1:0] MVL_CNT = CNT_W'(MVL);
  localparam logic [LEN_W-1:0] MVL_LEN = LEN_W'(MVL);

  logic [IDX_W-1:0] startQ;
  logic [CNT_W-1:0] remainQ;   // elements left, current strip included
  logic [LEN_W-1:0] lenQ;
  logic [CNT_W-1:0] oddPiece;

  assign oddPiece = count % MVL_CNT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ  <= '0;
      remainQ <= '0;
      lenQ    <= '0;
    end else if (strobe.load) begin
      startQ  <= baseIdx;
      remainQ <= count;
      lenQ    <= (oddPiece == '0) ? MVL_LEN : LEN_W'(oddPiece);
    end else if (strobe.advance) begin
      startQ  <= startQ + IDX_W'(lenQ);
      remainQ <= remainQ - CNT_W'(lenQ);
      lenQ    <= MVL_LEN;
    end
  end

  assign stripStart = startQ;
  assign stripLen   = lenQ;
  assign isLast     = (remainQ == CNT_W'(lenQ));

  // R5: an accepted strip is never empty nor longer than MVL
  p_len_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (lenQ != '0 && lenQ <= MVL_LEN));

  // R4: a strip never claims more elements than remain
  p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (remainQ >= CNT_W'(lenQ)));

endmodule

// File: rtl/strip_seq.sv
module strip_seq
  import strip_pkg::*;
#(
  parameter int MVL   = 64,
  parameter int CNT_W = 16,
  parameter int IDX_W = 16,
  parameter int LEN_W = $clog2(MVL + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [CNT_W-1:0] count,
  input  logic [IDX_W-1:0] baseIdx,
  output logic             busy,
  output logic             stripValid,
  input  logic             stripReady,
  output logic [IDX_W-1:0] stripStart,
  output logic [LEN_W-1:0] stripLen,
  output logic             stripLast,
  output logic             done
);

  ctrlStrobe_t strobe;
  logic        isLast;

  strip_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .countZero  (count == '0),
    .stripReady (stripReady),
    .isLast     (isLast),
    .strobe     (strobe),
    .stripValid (stripValid),
    .busy       (busy),
    .done       (done)
  );

  strip_dp #(
    .MVL   (MVL),
    .CNT_W (CNT_W),
    .IDX_W (IDX_W),
    .LEN_W (LEN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .count      (count),
    .baseIdx    (baseIdx),
    .stripStart (stripStart),
    .stripLen   (stripLen),
    .isLast     (isLast)
  );

  assign stripLast = isLast;

  // R8: a stalled strip holds its fields
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stripValid && !stripReady) |=>
      (stripValid && $stable(stripStart) && $stable(stripLen) && $stable(stripLast)));

  // R3: the next strip begins where the accepted one ended
  p_chain_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stripValid && stripReady && !stripLast) |=>
      (stripValid && stripStart == IDX_W'($past(stripStart) + IDX_W'($past(stripLen)))));

  // R2: strips after the first are full length
  p_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stripValid && stripReady && !stripLast) |=> (stripLen == LEN_W'(MVL)));

  // R12: accepting the last strip ends the sequence with done
  p_last_done_r12: assert property (@(posedge clk) disable iff (!rstN)
    (stripValid && stripReady && stripLast) |=> (done && !busy));

  // R10: a start while busy does not disturb a stalled strip
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startValid && !stripReady) |=> (busy && $stable(stripStart) && $stable(stripLen)));

endmodule

// File: tb/tb_strip_seq.sv
module tb_strip_seq;

  localparam int MVL = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [15:0] count = '0;
  logic [15:0] baseIdx = '0;
  logic        busy, stripValid, stripLast, done;
  logic        stripReady = 1'b0;
  logic [15:0] stripStart;
  logic [6:0]  stripLen;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int readyMode = 0;
  logic [7:0] lfsr = 8'hA5;

  typedef struct {
    logic [15:0] start;
    int          len;
    logic        last;
  } strip_t;

  strip_t expQ[$];
  logic   expectDone = 1'b0;
  logic   holdArmed = 1'b0;
  strip_t holdVal;

  strip_seq dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .count(count),
    .baseIdx(baseIdx), .busy(busy), .stripValid(stripValid),
    .stripReady(stripReady), .stripStart(stripStart), .stripLen(stripLen),
    .stripLast(stripLast), .done(done)
  );

  always #4 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ready pattern, changes just after each rising edge
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (readyMode)
      0: stripReady <= 1'b1;
      1: stripReady <= ~stripReady;
      default: stripReady <= lfsr[0];
    endcase
  end

  // monitor: pops the scoreboard on every accepted strip
  always @(negedge clk) begin
    if (rstN) begin
      if (expectDone) begin
        check(done == 1'b1, "R12 done after last", int'(done), 1);
        check(stripValid == 1'b0, "R12 idle after last", int'(stripValid), 0);
        expectDone = 1'b0;
      end
      if (holdArmed && stripValid) begin
        check(stripStart == holdVal.start && int'(stripLen) == holdVal.len &&
              stripLast == holdVal.last, "R8 hold", int'(stripStart), int'(holdVal.start));
      end
      holdArmed = 1'b0;
      if (stripValid && !stripReady) begin
        holdArmed    = 1'b1;
        holdVal.start = stripStart;
        holdVal.len   = int'(stripLen);
        holdVal.last  = stripLast;
      end
      if (stripValid && stripReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4 extra strip", int'(stripStart), -1);
        end else begin
          strip_t e;
          e = expQ.pop_front();
          check(stripStart == e.start, "R3 start", int'(stripStart), int'(e.start));
          check(int'(stripLen) == e.len, "R1/R2 length", int'(stripLen), e.len);
          check(stripLen >= 1 && stripLen <= MVL, "R5 bound", int'(stripLen), MVL);
          check(stripLast == e.last, "R9 last", int'(stripLast), int'(e.last));
          if (stripLast) expectDone = 1'b1;
        end
      end
    end
  end

  // driver: builds expected strips from the count, then pulses start
  task automatic runSeq(input int n, input logic [15:0] base, input int mode);
    int rem = n % MVL;
    int full = n / MVL;
    logic [15:0] s = base;
    readyMode = mode;
    if (rem != 0) begin
      expQ.push_back('{start: s, len: rem, last: (full == 0)});
      s = s + 16'(rem);
    end
    for (int i = 0; i < full; i++) begin
      expQ.push_back('{start: s, len: MVL, last: (i == full - 1)});
      s = s + 16'(MVL);
    end
    @(posedge clk); #1;
    startValid = 1'b1; count = 16'(n); baseIdx = base;
    @(posedge clk); #1;
    startValid = 1'b0;
    @(negedge clk);
    if (n == 0) begin
      check(done == 1'b1, "R7 zero done", int'(done), 1);
      check(stripValid == 1'b0, "R7 no strip", int'(stripValid), 0);
    end else begin
      check(stripValid == 1'b1, "R12 first strip due", int'(stripValid), 1);
    end
    while (busy || expectDone) @(negedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R4 strip count", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(stripValid == 1'b0 && done == 1'b0 && busy == 1'b0, "R11 reset", int'(stripValid), 0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    check(stripValid == 1'b0 && busy == 1'b0, "R11 after reset", int'(busy), 0);

    runSeq(0, 16'h0100, 0);       // R7
    runSeq(5, 16'h0010, 0);       // R1 short only
    runSeq(1, 16'h0000, 1);       // R1 single element
    runSeq(64, 16'h0200, 0);      // R6 exact single
    runSeq(128, 16'h0300, 1);     // R6 exact multiple
    runSeq(130, 16'h0400, 2);     // R1 R2 R3
    runSeq(200, 16'hFFF0, 2);     // R3 index wrap
    runSeq(65535, 16'h0000, 0);   // R4 large

    // R10: start while busy is ignored
    begin
      readyMode = 1;
      expQ.push_back('{start: 16'h0500, len: 8, last: 1'b0});
      expQ.push_back('{start: 16'h0508, len: 64, last: 1'b1});
      @(posedge clk); #1;
      startValid = 1'b1; count = 16'd72; baseIdx = 16'h0500;
      @(posedge clk); #1;
      count = 16'd3; baseIdx = 16'h7000;   // held high while busy
      @(posedge clk); #1;
      @(posedge clk); #1;
      startValid = 1'b0;
      while (busy || expectDone) @(negedge clk);
      @(negedge clk);
      check(expQ.size() == 0, "R10 no restart", expQ.size(), 0);
      check(busy == 1'b0 && stripValid == 1'b0, "R10 idle after", int'(stripValid), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule